// File: doc/BRIEF.md
# Banked register space decoder

This block decodes 8-bit register-space addresses into two banks of 256 byte-wide locations. The bank is chosen by a bank-select bit in an 8-bit flags register that the block holds. The flags register sits at one fixed address, F7h, in both banks. For every other address, the bank-select bit picks whether an access lands in bank 0 or bank 1.

A core drives the bus with address, write data, write enable and read enable. Read data comes back one cycle after the read. The block drives one-hot select vectors to the peripheral registers of each bank. In this project those registers are modelled as two internal arrays.

The flags register can change in three ways:
- a bus write to F7h;
- a bitwise OR with an immediate operand;
- a direct load from the core.

The current flags value is always driven out to the core.

Top module: `bank_reg_decoder`

## Requirements
- R1: After reset, flags equals 02h (only bit 1 set, bank-select bit 4 clear, so bank 0 is selected) and rdata equals 00h.
- R2: A write (`bus_we`=1) to an address other than F7h stores `bus_wdata` in the selected bank only. In the same cycle, exactly one bit of that bank's select vector is set, at the bit index equal to the address. The other bank's vector is all zero.
- R3: A read (`bus_re`=1) of an address other than F7h returns the selected bank's stored byte on `bus_rdata` in the cycle after the read. When `bus_re` is 0, `bus_rdata` holds its last value.
- R4: Flags bit 4 selects the bank: 1 selects bank 1 and 0 selects bank 0. A bank-1 select is asserted only when bit 4 is 1.
- R5: A read of F7h returns the flags value in either bank, with the same one-cycle latency.
- R6: A write to F7h in either bank loads `bus_wdata` into flags. It asserts no select bit and stores nothing in either bank.
- R7: With `or_en`=1, flags becomes flags OR `or_imm` on the next clock edge.
- R8: With `flag_ld`=1, flags becomes `flag_ld_data` on the next clock edge.
- R9: Priority among flag updates in one cycle, highest first: `flag_ld`, then a bus write to F7h, then `or_en`.
- R10: A change to flags takes effect for bank selection from the next cycle. An access made in the same cycle as the change uses the old bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register-space address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Registered read data |
| or_en | input | 1 | OR immediate into flags |
| or_imm | input | 8 | OR operand |
| flag_ld | input | 1 | Direct flags load |
| flag_ld_data | input | 8 | Flags load value |
| bank0_sel | output | 256 | One-hot select for bank 0 locations |
| bank1_sel | output | 256 | One-hot select for bank 1 locations |
| flags | output | 8 | Flags register |

## Verification
The hardest situation to reach is a bank access in the same cycle as a flags change. Only the OR and load ports can change the flags while the bus touches another address at that moment. The bench therefore pulses `or_en` together with a write to a plain address. It then returns to bank 0 and reads that address back to prove the write used the old bank. Priority is reached by asserting the load, a bus write to F7h and the OR in one cycle, then dropping the highest one.

// File: rtl/bank_reg_decoder.sv
module bank_reg_decoder #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int FLAG_ADDR = 'hF7,
  parameter int BANK_BIT  = 4,
  parameter int FLAG_RST  = 'h02
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 or_en,
  input  logic [DATA_W-1:0]    or_imm,
  input  logic                 flag_ld,
  input  logic [DATA_W-1:0]    flag_ld_data,
  output logic [(1<<ADDR_W)-1:0] bank0_sel,
  output logic [(1<<ADDR_W)-1:0] bank1_sel,
  output logic [DATA_W-1:0]    flags
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DEPTH-1:0] ONE = {{(DEPTH-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] mem0 [DEPTH];
  logic [DATA_W-1:0] mem1 [DEPTH];

  logic flag_hit, bank, access;
  assign flag_hit = (bus_addr == ADDR_W'(FLAG_ADDR));
  assign bank     = flags[BANK_BIT];
  assign access   = (bus_we || bus_re) && !flag_hit;

  assign bank0_sel = (access && !bank) ? (ONE << bus_addr) : '0;
  assign bank1_sel = (access &&  bank) ? (ONE << bus_addr) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                  flags <= DATA_W'(FLAG_RST);
    else if (flag_ld)            flags <= flag_ld_data;
    else if (bus_we && flag_hit) flags <= bus_wdata;
    else if (or_en)              flags <= flags | or_imm;
  end

  always_ff @(posedge clk) begin
    if (bus_we && !flag_hit) begin
      if (bank) mem1[bus_addr] <= bus_wdata;
      else      mem0[bus_addr] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        bus_rdata <= '0;
    else if (bus_re)   bus_rdata <= flag_hit ? flags : (bank ? mem1[bus_addr] : mem0[bus_addr]);
  end
endmodule

// File: rtl/bank_reg_decoder_chk.sv
module bank_reg_decoder_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int FLAG_ADDR = 'hF7,
  parameter int BANK_BIT  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [DATA_W-1:0]      bus_wdata,
  input logic                   bus_we,
  input logic                   bus_re,
  input logic [DATA_W-1:0]      bus_rdata,
  input logic                   or_en,
  input logic [DATA_W-1:0]      or_imm,
  input logic                   flag_ld,
  input logic [DATA_W-1:0]      flag_ld_data,
  input logic [(1<<ADDR_W)-1:0] bank0_sel,
  input logic [(1<<ADDR_W)-1:0] bank1_sel,
  input logic [DATA_W-1:0]      flags
);
  logic fhit;
  assign fhit = (bus_addr == ADDR_W'(FLAG_ADDR));

  p_sel_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bank0_sel, bank1_sel}));

  p_bank1_needs_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank1_sel) |-> flags[BANK_BIT]);

  p_flag_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && fhit) |=> bus_rdata == $past(flags));

  p_flag_addr_no_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fhit |-> (bank0_sel == '0 && bank1_sel == '0));

  p_or_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (or_en && !flag_ld && !(bus_we && fhit)) |=> flags == ($past(flags) | $past(or_imm)));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld |=> flags == $past(flag_ld_data));

  p_bus_flag_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && fhit && !flag_ld) |=> flags == $past(bus_wdata));

  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

bind bank_reg_decoder bank_reg_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_ADDR(FLAG_ADDR), .BANK_BIT(BANK_BIT)
) u_chk (.*);

// File: tb/test_bank_reg_decoder.sv
module test_bank_reg_decoder;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] OP_WR = 0, OP_RD = 1, OP_OR = 2, OP_LD = 3, OP_FL = 4;
  localparam int NV = 20;
  localparam logic [27:0] VEC [NV] = '{
    {OP_WR, 8'h10, 8'hA1, 8'h00},
    {OP_RD, 8'h10, 8'h00, 8'hA1},
    {OP_OR, 8'h00, 8'h10, 8'h00},
    {OP_FL, 8'h00, 8'h00, 8'h12},
    {OP_WR, 8'h10, 8'hB2, 8'h00},
    {OP_RD, 8'h10, 8'h00, 8'hB2},
    {OP_RD, 8'hF7, 8'h00, 8'h12},
    {OP_LD, 8'h00, 8'h02, 8'h00},
    {OP_RD, 8'h10, 8'h00, 8'hA1},
    {OP_RD, 8'hF7, 8'h00, 8'h02},
    {OP_WR, 8'hFF, 8'h5C, 8'h00},
    {OP_RD, 8'hFF, 8'h00, 8'h5C},
    {OP_WR, 8'h00, 8'hC3, 8'h00},
    {OP_RD, 8'h00, 8'h00, 8'hC3},
    {OP_WR, 8'hF7, 8'h13, 8'h00},
    {OP_FL, 8'h00, 8'h00, 8'h13},
    {OP_WR, 8'h00, 8'h3D, 8'h00},
    {OP_RD, 8'h00, 8'h00, 8'h3D},
    {OP_WR, 8'hF7, 8'h02, 8'h00},
    {OP_RD, 8'h00, 8'h00, 8'hC3}
  };

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, or_imm = 0, flag_ld_data = 0;
  logic bus_we = 0, bus_re = 0, or_en = 0, flag_ld = 0;
  logic [7:0] bus_rdata, flags;
  logic [255:0] bank0_sel, bank1_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_reg_decoder i_bank_reg_decoder (.*);

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_we = 0; bus_re = 0; or_en = 0; flag_ld = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 flags", flags, 8'h02);
    chk("R1 rdata", bus_rdata, 8'h00);

    foreach (VEC[i]) begin
      bus_addr = VEC[i][23:16];
      case (VEC[i][27:24])
        OP_WR: begin bus_wdata = VEC[i][15:8]; bus_we = 1; end
        OP_RD: bus_re = 1;
        OP_OR: begin or_imm = VEC[i][15:8]; or_en = 1; end
        OP_LD: begin flag_ld_data = VEC[i][15:8]; flag_ld = 1; end
        default: ;
      endcase
      if (VEC[i][27:24] == OP_FL) chk("R7/R6 flags", flags, VEC[i][7:0]);
      step();
      if (VEC[i][27:24] == OP_RD) chk("R3/R4/R5 read", bus_rdata, VEC[i][7:0]);
    end

    // R3 hold when no read
    step();
    chk("R3 hold", bus_rdata, 8'hC3);

    // R2 select one-hot in bank 0
    bus_addr = 8'h20; bus_wdata = 8'h44; bus_we = 1; #1;
    chk("R2 sel0", bank0_sel, 256'd1 << 8'h20);
    chk("R2 sel1", bank1_sel, 256'd0);
    step();

    // R6 F7 asserts no select
    bus_addr = 8'hF7; bus_wdata = 8'h02; bus_we = 1; #1;
    chk("R6 no sel", bank0_sel | bank1_sel, 256'd0);
    step();

    // R9 priority: load beats bus write beats or
    bus_addr = 8'hF7; bus_wdata = 8'h55; bus_we = 1;
    or_imm = 8'h80; or_en = 1; flag_ld_data = 8'h06; flag_ld = 1;
    step();
    chk("R9 load wins", flags, 8'h06);
    bus_addr = 8'hF7; bus_wdata = 8'h42; bus_we = 1; or_imm = 8'h01; or_en = 1;
    step();
    chk("R9 bus write over or", flags, 8'h42);
    flag_ld_data = 8'h02; flag_ld = 1;
    step();

    // R8 load sets bank 1; R4 sel1
    flag_ld_data = 8'h10; flag_ld = 1;
    step();
    chk("R8 load", flags, 8'h10);
    bus_addr = 8'h20; bus_re = 1; #1;
    chk("R4 sel1", bank1_sel, 256'd1 << 8'h20);
    step();
    flag_ld_data = 8'h02; flag_ld = 1;
    step();

    // R10 same-cycle OR uses old bank
    bus_addr = 8'h30; bus_wdata = 8'h77; bus_we = 1; or_imm = 8'h10; or_en = 1; #1;
    chk("R10 old bank sel", bank0_sel, 256'd1 << 8'h30);
    step();
    chk("R10 flags", flags, 8'h12);
    bus_addr = 8'h30; bus_wdata = 8'h99; bus_we = 1;
    step();
    flag_ld_data = 8'h02; flag_ld = 1;
    step();
    bus_addr = 8'h30; bus_re = 1;
    step();
    chk("R10 bank0 kept data", bus_rdata, 8'h77);
    or_imm = 8'h10; or_en = 1;
    step();
    bus_addr = 8'h30; bus_re = 1;
    step();
    chk("R10 bank1 data", bus_rdata, 8'h99);

    // R1 reset again
    rst_n = 0;
    step();
    chk("R1 flags re-reset", flags, 8'h02);
    chk("R1 rdata re-reset", bus_rdata, 8'h00);
    rst_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule